// File: doc/BRIEF.md
# Dual-Window Power Limiter

This block is a closed-loop regulator for a throttle duty value. A power estimator elsewhere in the chip delivers a fresh reading, with a one-cycle valid strobe, about once every 512 host clock cycles. On each strobe the limiter compares the reading against two nested hysteresis windows and nudges its duty output up or down. The duty output feeds a clock-throttling modulator: 255 means full speed, and lower values slow the clock more.

The wide outer window handles large excursions with big steps. The narrow inner window, which software places entirely inside the outer one, trims the duty with small steps. Each window has its own step for raising and its own step for lowering. A reading inside the inner window leaves the duty alone. The result saturates at 0 and at 255 rather than wrapping. When the limiter is disabled, the duty sits at 255. When it is enabled again, regulation starts from 255.

Top module: `power_limiter`

## Requirements
- R1: While reset is asserted, and after reset is released, the duty output reads 255 until the first accepted sample.
- R2: While the enable input is low, the duty output is 255 at every clock edge, and sample strobes have no effect on it.
- R3: An accepted sample whose reading is strictly greater than the outer high threshold lowers the duty by the outer down step, saturating at 0.
- R4: An accepted sample whose reading is greater than the inner high threshold but not greater than the outer high threshold lowers the duty by the inner down step, saturating at 0.
- R5: An accepted sample whose reading is strictly less than the outer low threshold raises the duty by the outer up step, saturating at 255.
- R6: An accepted sample whose reading is at least the outer low threshold but less than the inner low threshold raises the duty by the inner up step, saturating at 255.
- R7: An accepted sample whose reading lies between the inner low and inner high thresholds, both inclusive, leaves the duty unchanged.
- R8: The duty changes only in the cycle after a valid strobe; in all other cycles it holds its value while enabled.
- R9: Readings and thresholds are compared as 16-bit unsigned numbers, so a reading of 0xFFFF counts as above every threshold below it.
- R10: After enable goes low and then high again, the duty restarts from 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Limiter enable |
| pwr_vld | input | 1 | One-cycle strobe marking a new power reading |
| pwr | input | 16 | Power reading, unsigned |
| outer_lo | input | 16 | Outer window low threshold |
| outer_hi | input | 16 | Outer window high threshold |
| inner_lo | input | 16 | Inner window low threshold |
| inner_hi | input | 16 | Inner window high threshold |
| outer_up | input | 8 | Step added below the outer window |
| outer_dn | input | 8 | Step subtracted above the outer window |
| inner_up | input | 8 | Step added between the outer and inner low thresholds |
| inner_dn | input | 8 | Step subtracted between the inner and outer high thresholds |
| duty | output | 8 | Duty value sent to the throttle |

## Verification
The bench sweeps the reading across every value from 0 to past the outer high threshold, in both directions. This exercises each threshold's exact boundary. A design that used the wrong comparison at a threshold would apply the step of the neighbouring zone on that single value. Long runs of extreme readings drive the duty into both rails, where arithmetic no wider than the duty would wrap to a large or small value instead of sticking at 0 or 255. Maximum 255 steps and a 0xFFFF reading check that the widest step and the top of the unsigned range are handled. Strobes while disabled, idle cycles without a strobe, and a disable and re-enable after the duty has been pulled low check that the duty neither drifts nor resumes from a stale value.

// File: rtl/power_limiter.sv
module power_limiter #(
  parameter int PWR_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pwr_vld,
  input  logic [PWR_W-1:0]  pwr,
  input  logic [PWR_W-1:0]  outer_lo,
  input  logic [PWR_W-1:0]  outer_hi,
  input  logic [PWR_W-1:0]  inner_lo,
  input  logic [PWR_W-1:0]  inner_hi,
  input  logic [DUTY_W-1:0] outer_up,
  input  logic [DUTY_W-1:0] outer_dn,
  input  logic [DUTY_W-1:0] inner_up,
  input  logic [DUTY_W-1:0] inner_dn,
  output logic [DUTY_W-1:0] duty
);
  localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};

  logic              above_outer, above_inner, below_outer, below_inner;
  logic              go_up, go_dn;
  logic [DUTY_W-1:0] step;
  logic [DUTY_W:0]   sum, diff;
  logic [DUTY_W-1:0] nxt;

  assign above_outer = pwr > outer_hi;
  assign above_inner = pwr > inner_hi;
  assign below_outer = pwr < outer_lo;
  assign below_inner = pwr < inner_lo;

  assign go_dn = above_inner;
  assign go_up = !above_inner && below_inner;

  always_comb begin
    if (above_outer)      step = outer_dn;
    else if (above_inner) step = inner_dn;
    else if (below_outer) step = outer_up;
    else                  step = inner_up;
  end

  assign sum  = {1'b0, duty} + {1'b0, step};
  assign diff = {1'b0, duty} - {1'b0, step};

  always_comb begin
    if (go_dn)      nxt = diff[DUTY_W] ? '0 : diff[DUTY_W-1:0];
    else if (go_up) nxt = sum[DUTY_W] ? FULL : sum[DUTY_W-1:0];
    else            nxt = duty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) duty <= FULL;
    else if (pwr_vld)  duty <= nxt;
  end
endmodule

// File: rtl/power_limiter_chk.sv
module power_limiter_chk #(
  parameter int PWR_W  = 16,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              pwr_vld,
  input logic [PWR_W-1:0]  pwr,
  input logic [PWR_W-1:0]  outer_lo,
  input logic [PWR_W-1:0]  outer_hi,
  input logic [PWR_W-1:0]  inner_lo,
  input logic [PWR_W-1:0]  inner_hi,
  input logic [DUTY_W-1:0] duty
);
  localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};

  p_disabled_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> duty == FULL);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pwr_vld) |=> $stable(duty));

  p_inner_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_vld && pwr >= inner_lo && pwr <= inner_hi) |=> $stable(duty));

  p_outer_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_vld && pwr > outer_hi) |=> duty <= $past(duty));

  p_inner_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_vld && pwr > inner_hi && pwr <= outer_hi) |=> duty <= $past(duty));

  p_outer_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_vld && pwr < outer_lo && pwr <= inner_hi) |=> duty >= $past(duty));

  p_inner_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_vld && pwr >= outer_lo && pwr < inner_lo && pwr <= inner_hi)
    |=> duty >= $past(duty));

  p_restart_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> duty == FULL);
endmodule

bind power_limiter power_limiter_chk #(.PWR_W(PWR_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwr_vld(pwr_vld), .pwr(pwr),
  .outer_lo(outer_lo), .outer_hi(outer_hi), .inner_lo(inner_lo),
  .inner_hi(inner_hi), .duty(duty)
);

// File: tb/tb_power_limiter.sv
module tb_power_limiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        pwr_vld = 1'b0;
  logic [15:0] pwr = '0;
  logic [15:0] outer_lo, outer_hi, inner_lo, inner_hi;
  logic [7:0]  outer_up, outer_dn, inner_up, inner_dn;
  logic [7:0]  duty;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_duty = 255;

  always #(CLK_PERIOD/2) clk = ~clk;

  power_limiter dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pwr_vld(pwr_vld), .pwr(pwr),
    .outer_lo(outer_lo), .outer_hi(outer_hi), .inner_lo(inner_lo),
    .inner_hi(inner_hi), .outer_up(outer_up), .outer_dn(outer_dn),
    .inner_up(inner_up), .inner_dn(inner_dn), .duty(duty)
  );

  task automatic check(input string req, input int expv);
    n_cmp++;
    if (int'(duty) != expv) begin
      n_bad++;
      $display("FAIL %s: duty=%0d expected=%0d", req, duty, expv);
    end
  endtask

  task automatic cfg(input int olo, ohi, ilo, ihi, ou, od, iu, idn);
    outer_lo = 16'(olo); outer_hi = 16'(ohi);
    inner_lo = 16'(ilo); inner_hi = 16'(ihi);
    outer_up = 8'(ou); outer_dn = 8'(od);
    inner_up = 8'(iu); inner_dn = 8'(idn);
  endtask

  // Apply one strobe and compare against the arithmetic model.
  task automatic sample(input int p);
    string req;
    int v;
    @(negedge clk);
    pwr = 16'(p);
    pwr_vld = 1'b1;
    if (!en) begin
      req = "R2"; v = 255;
    end else if (p > int'(outer_hi)) begin
      req = (p == 65535) ? "R9" : "R3"; v = exp_duty - int'(outer_dn);
    end else if (p > int'(inner_hi)) begin
      req = "R4"; v = exp_duty - int'(inner_dn);
    end else if (p < int'(outer_lo)) begin
      req = "R5"; v = exp_duty + int'(outer_up);
    end else if (p < int'(inner_lo)) begin
      req = "R6"; v = exp_duty + int'(inner_up);
    end else begin
      req = "R7"; v = exp_duty;
    end
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    exp_duty = v;
    @(negedge clk);
    pwr_vld = 1'b0;
    check(req, exp_duty);
  endtask

  initial begin
    cfg(100, 130, 110, 120, 20, 30, 5, 10);
    repeat (3) @(negedge clk);
    check("R1", 255);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 255);

    // Disabled: strobes ignored.
    sample(300);
    sample(0);
    en = 1'b1;
    @(negedge clk);
    check("R1", 255);

    // Upward and downward sweeps across every threshold.
    for (int p = 0; p <= 200; p++) sample(p);
    for (int p = 200; p >= 0; p--) sample(p);

    // Drive to the low rail, then to the high rail.
    for (int i = 0; i < 12; i++) sample(500);
    sample(65535);
    for (int i = 0; i < 15; i++) sample(0);

    // No strobe: duty holds (R8).
    sample(125);
    sample(125);
    pwr = 16'd500;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R8", exp_duty);
    end

    // Disable, then re-enable after the duty has been pulled down (R10).
    for (int i = 0; i < 4; i++) sample(140);
    en = 1'b0;
    @(negedge clk);
    exp_duty = 255;
    check("R2", 255);
    sample(1000);
    en = 1'b1;
    @(negedge clk);
    check("R10", 255);
    sample(115);

    // Second configuration: maximum steps and thresholds near the top of the range.
    cfg(65000, 65500, 65200, 65300, 255, 255, 1, 1);
    for (int p = 64990; p <= 65535; p += 5) sample(p);
    for (int p = 65535; p >= 64990; p -= 7) sample(p);
    sample(65535);
    sample(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule